// File: doc/BRIEF.md
# Subcycle-Sequenced Single-Bus Add Datapath

This block is a 16-bit accumulator datapath in which every transfer travels over one shared data bus. A subcycle counter steps through nine subcycles per instruction. Each subcycle has two clock phases, and a register load always happens at the end of the second phase. In each subcycle the decoder enables at most one bus source and the register loads that take from it. Every load strobe is built as the OR of the decode terms (instruction class and subcycle) that need it.

The only full instruction is ADD. The operand field selects a memory word, and that word is added to the accumulator G. The sequence of transfers is fixed:
- the operand field goes to the address register;
- the memory word is captured into the buffer register and passed to ALU input Y;
- G is passed to ALU input X;
- the adder function is raised for two subcycles, and the result register Z is loaded only at the end of the second one, so the ripple carry has time to settle;
- Z is written back to G.

Fetch is a stub: the instruction word presented on a port is loaded into the instruction register. Any other opcode runs the sequence with no transfers at all.

Memory sits outside the block. It reads combinationally from the address register.

Top module: `subcycle_add_datapath`

## Requirements
- R1: While reset is held, and on the first falling edge after it is released, the subcycle is 0, the phase is 0, the accumulator is 0000 and the bus reads the idle value 0000.
- R2: The phase toggles on every clock. The subcycle advances on each clock that ends phase 1, counting 0 to 8 and then wrapping to 0, so one instruction takes 18 clocks.
- R3: In subcycle 1, the bus carries `instr_word`, and the instruction register loads it. Opcode bits [15:12] equal to 4'hA mean ADD, and bits [11:0] are the operand address.
- R4: For ADD, subcycle 3 puts the zero-extended operand field on the bus and loads the address register. `mem_addr` shows that address from subcycle 4 onward.
- R5: For ADD, the buffer register captures `mem_rdata` at the end of phase 0 of subcycle 4. It then drives the bus in phase 1, and Y loads from the bus.
- R6: For ADD, subcycle 5 drives G onto the bus and loads X.
- R7: For ADD, the adder function is active in subcycles 6 and 7, and Z loads only at the end of subcycle 7. Subcycle 8 drives Z onto the bus and loads G, so `acc_q` equals the old G plus the memory word, modulo 2^16, from the start of the next instruction.
- R8: At most one bus source is enabled in any cycle. When none is enabled (subcycles 0, 2, 6 and 7), the bus reads 0000.
- R9: For an opcode other than 4'hA, subcycles 3 to 8 enable no bus source and the accumulator keeps its value.
- R10: The carry out of the top stage is discarded. FFFF plus 0001 leaves G at 0000, and adding a zero word leaves G unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_word | input | 16 | Instruction word for the fetch stub |
| mem_rdata | input | 16 | Memory read data at `mem_addr` |
| mem_addr | output | 12 | Address register contents |
| acc_q | output | 16 | Accumulator G |
| bus_q | output | 16 | Shared data bus |
| sc_q | output | 4 | Current subcycle |
| phase_q | output | 1 | Current phase within the subcycle |

## Verification
Each bus transfer is due in phase 1 of its subcycle. That is the clock 2·s+1 counted from the first phase of the instruction. The bench samples the bus there on the falling edge.

The new accumulator value comes from the clock edge that ends subcycle 8. So `acc_q` is checked at the falling edge 18 clocks after the instruction began, when the subcycle reads 0 again, and `mem_addr` is checked at that same point.

Expected bus words and sums come from a bench model that adds memory words modulo 65536. The bench keeps step with the design by counting clocks. It compares its own count against `sc_q` and `phase_q` on every falling edge.

// File: rtl/sadp_pkg.sv
package sadp_pkg;
  localparam int NSC = 9;
  localparam int SCW = 4;

  localparam int NSRC     = 5;
  localparam int SRC_EXT  = 0;
  localparam int SRC_IROP = 1;
  localparam int SRC_MBR  = 2;
  localparam int SRC_ACC  = 3;
  localparam int SRC_SUM  = 4;

  localparam int NSTB    = 8;
  localparam int STB_IR  = 0;
  localparam int STB_MAR = 1;
  localparam int STB_MBR = 2;
  localparam int STB_Y   = 3;
  localparam int STB_X   = 4;
  localparam int STB_Z   = 5;
  localparam int STB_G   = 6;
  localparam int STB_FN  = 7;

  // one-bit full adder: {carry, sum}
  function automatic logic [1:0] full_add(input logic a, input logic b, input logic ci);
    full_add = {(a & b) | (a & ci) | (b & ci), a ^ b ^ ci};
  endfunction

  // subcycles in which a bus source is enabled, per instruction class
  function automatic logic [NSC-1:0] send_mask(input int src, input bit add_cls);
    logic [NSC-1:0] m;
    m = '0;
    if (!add_cls) begin
      if (src == SRC_EXT) m[1] = 1'b1;
    end else begin
      case (src)
        SRC_IROP: m[3] = 1'b1;
        SRC_MBR:  m[4] = 1'b1;
        SRC_ACC:  m[5] = 1'b1;
        SRC_SUM:  m[8] = 1'b1;
        default:  m = '0;
      endcase
    end
    return m;
  endfunction

  // subcycles in which a load or function strobe is raised, per class
  function automatic logic [NSC-1:0] strobe_mask(input int stb, input bit add_cls);
    logic [NSC-1:0] m;
    m = '0;
    if (!add_cls) begin
      if (stb == STB_IR) m[1] = 1'b1;
    end else begin
      case (stb)
        STB_MAR: m[3] = 1'b1;
        STB_MBR: m[4] = 1'b1;
        STB_Y:   m[4] = 1'b1;
        STB_X:   m[5] = 1'b1;
        STB_FN:  begin m[6] = 1'b1; m[7] = 1'b1; end
        STB_Z:   m[7] = 1'b1;
        STB_G:   m[8] = 1'b1;
        default: m = '0;
      endcase
    end
    return m;
  endfunction
endpackage

// File: rtl/sadp_ripple_adder.sv
module sadp_ripple_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         carry_out
);
  logic [W:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_stage
    logic [1:0] fa;
    assign fa         = sadp_pkg::full_add(a[i], b[i], carry[i]);
    assign sum[i]     = fa[0];
    assign carry[i+1] = fa[1];
  end

  assign carry_out = carry[W];
endmodule

// File: rtl/sadp_sequencer.sv
module sadp_sequencer
  import sadp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_add,
  output logic [SCW-1:0]   sc,
  output logic             phase,
  output logic [NSRC-1:0]  send_en,
  output logic [NSTB-1:0]  strobe
);
  localparam logic [SCW-1:0] SC_LAST = SCW'(NSC - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc    <= '0;
      phase <= 1'b0;
    end else begin
      phase <= ~phase;
      if (phase) sc <= (sc == SC_LAST) ? '0 : sc + 1'b1;
    end
  end

  // decode terms: one per (class, subcycle) pair
  logic [NSC-1:0] dec_any;
  logic [NSC-1:0] dec_add;
  for (genvar s = 0; s < NSC; s++) begin : g_dec
    assign dec_any[s] = (sc == SCW'(s));
    assign dec_add[s] = is_add && (sc == SCW'(s));
  end

  // each control line is the OR of its decode terms
  for (genvar k = 0; k < NSRC; k++) begin : g_send
    localparam logic [NSC-1:0] MF = send_mask(k, 1'b0);
    localparam logic [NSC-1:0] MA = send_mask(k, 1'b1);
    assign send_en[k] = |(dec_any & MF) | |(dec_add & MA);
  end

  for (genvar k = 0; k < NSTB; k++) begin : g_stb
    localparam logic [NSC-1:0] MF = strobe_mask(k, 1'b0);
    localparam logic [NSC-1:0] MA = strobe_mask(k, 1'b1);
    assign strobe[k] = |(dec_any & MF) | |(dec_add & MA);
  end
endmodule

// File: rtl/sadp_bus.sv
module sadp_bus #(
  parameter int          W    = 16,
  parameter int          NS   = 5,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic [NS-1:0][W-1:0] src_data,
  input  logic [NS-1:0]        src_en,
  output logic [W-1:0]         bus
);
  logic [NS-1:0][W-1:0] gated;
  for (genvar i = 0; i < NS; i++) begin : g_gate
    assign gated[i] = src_data[i] & {W{src_en[i]}};
  end

  always_comb begin
    bus = (src_en == '0) ? IDLE : '0;
    for (int i = 0; i < NS; i++) bus = bus | gated[i];
  end
endmodule

// File: rtl/subcycle_add_datapath.sv
module subcycle_add_datapath
  import sadp_pkg::*;
#(
  parameter int          DW     = 16,
  parameter int          AW     = 12,
  parameter int          OPW    = 4,
  parameter logic [3:0]  ADD_OP = 4'hA,
  parameter logic [15:0] IDLE   = 16'h0000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  instr_word,
  input  logic [DW-1:0]  mem_rdata,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  acc_q,
  output logic [DW-1:0]  bus_q,
  output logic [SCW-1:0] sc_q,
  output logic           phase_q
);
  logic [DW-1:0] ir, mbr, x_r, y_r, z_r, g_r;
  logic [AW-1:0] mar;
  logic [DW-1:0] bus;
  logic [DW-1:0] adder_sum, alu_res;
  logic          carry_out;
  logic          is_add;
  logic [SCW-1:0]  sc;
  logic            phase;
  logic [NSRC-1:0] send_en;
  logic [NSTB-1:0] strobe;
  logic ld_ir, ld_mar, cap_mbr, ld_y, ld_x, ld_z, ld_g, add_fn;

  assign is_add = (ir[DW-1 -: OPW] == OPW'(ADD_OP));

  sadp_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .is_add(is_add),
    .sc(sc), .phase(phase), .send_en(send_en), .strobe(strobe)
  );

  // loads take effect on the edge ending phase 1; memory capture ends phase 0
  assign ld_ir   = strobe[STB_IR]  &  phase;
  assign ld_mar  = strobe[STB_MAR] &  phase;
  assign cap_mbr = strobe[STB_MBR] & ~phase;
  assign ld_y    = strobe[STB_Y]   &  phase;
  assign ld_x    = strobe[STB_X]   &  phase;
  assign ld_z    = strobe[STB_Z]   &  phase;
  assign ld_g    = strobe[STB_G]   &  phase;
  assign add_fn  = strobe[STB_FN];

  logic [NSRC-1:0][DW-1:0] src_data;
  assign src_data[SRC_EXT]  = instr_word;
  assign src_data[SRC_IROP] = DW'(ir[AW-1:0]);
  assign src_data[SRC_MBR]  = mbr;
  assign src_data[SRC_ACC]  = g_r;
  assign src_data[SRC_SUM]  = z_r;

  sadp_bus #(.W(DW), .NS(NSRC), .IDLE(IDLE[DW-1:0])) u_bus (
    .src_data(src_data), .src_en(send_en), .bus(bus)
  );

  sadp_ripple_adder #(.W(DW)) u_add (
    .a(x_r), .b(y_r), .sum(adder_sum), .carry_out(carry_out)
  );

  assign alu_res = add_fn ? adder_sum : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir  <= '0;
      mar <= '0;
      mbr <= '0;
      x_r <= '0;
      y_r <= '0;
      z_r <= '0;
      g_r <= '0;
    end else begin
      if (ld_ir)   ir  <= bus;
      if (ld_mar)  mar <= bus[AW-1:0];
      if (cap_mbr) mbr <= mem_rdata;
      if (ld_y)    y_r <= bus;
      if (ld_x)    x_r <= bus;
      if (ld_z)    z_r <= alu_res;
      if (ld_g)    g_r <= bus;
    end
  end

  assign mem_addr = mar;
  assign acc_q    = g_r;
  assign bus_q    = bus;
  assign sc_q     = sc;
  assign phase_q  = phase;
endmodule

// File: rtl/sadp_checker.sv
module sadp_checker #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    sc,
  input logic          phase,
  input logic [4:0]    send_en,
  input logic [DW-1:0] bus,
  input logic          ld_mar,
  input logic          ld_z,
  input logic          ld_g,
  input logic          add_fn,
  input logic          is_add,
  input logic [DW-1:0] ir,
  input logic [AW-1:0] mar,
  input logic [DW-1:0] z_r,
  input logic [DW-1:0] g_r
);
  assert_one_driver_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(send_en));

  assert_idle_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (send_en == '0) |-> (bus == '0));

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sc == 4'd8 && phase) |=> (sc == 4'd0 && !phase));

  assert_phase_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !phase |=> phase);

  assert_mar_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mar |=> (mar == $past(ir[AW-1:0])));

  assert_z_deferred_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_z |-> (add_fn && $past(add_fn, 2)));

  assert_g_from_z_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_g |=> (g_r == $past(z_r)));

  assert_quiet_other_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_add && sc >= 4'd3) |-> (send_en == '0));

  assert_acc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_add && sc >= 4'd2 && sc != 4'd8) |=> $stable(g_r));
endmodule

bind subcycle_add_datapath sadp_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sc(sc), .phase(phase), .send_en(send_en),
  .bus(bus), .ld_mar(ld_mar), .ld_z(ld_z), .ld_g(ld_g), .add_fn(add_fn),
  .is_add(is_add), .ir(ir), .mar(mar), .z_r(z_r), .g_r(g_r)
);

// File: tb/subcycle_add_datapath_tb.sv
module subcycle_add_datapath_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr_word = '0;
  logic [15:0] mem_rdata;
  logic [11:0] mem_addr;
  logic [15:0] acc_q, bus_q;
  logic [3:0]  sc_q;
  logic        phase_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] mem [256];
  logic [15:0] model_g = '0;

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];

  subcycle_add_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .instr_word(instr_word), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .acc_q(acc_q), .bus_q(bus_q), .sc_q(sc_q), .phase_q(phase_q)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // entered at a falling edge with subcycle 0 phase 0; leaves at the next one
  task automatic run_instr(input logic [3:0] op, input logic [7:0] addr);
    logic [15:0] word, old_g, new_g;
    bit add;
    word  = {op, 4'h0, addr};
    add   = (op == 4'hA);
    old_g = model_g;
    new_g = add ? 16'((32'(old_g) + 32'(mem[addr])) % 32'd65536) : old_g;
    instr_word = word;
    for (int k = 0; k < 18; k++) begin
      int s;
      int p;
      s = k / 2;
      p = k % 2;
      chk(sc_q == 4'(s) && phase_q == 1'(p), "R2 subcycle/phase", {11'd0, phase_q, sc_q}, 16'(p * 16 + s));
      if (s == 0 || s == 2 || s == 6 || s == 7)
        chk(bus_q == 16'h0000, "R8 idle bus", bus_q, 16'h0000);
      if (s == 1 && p == 1) chk(bus_q == word, "R3 fetch stub bus", bus_q, word);
      if (!add && s >= 3) chk(bus_q == 16'h0000, "R9 no transfer", bus_q, 16'h0000);
      if (add && p == 1) begin
        if (s == 3) chk(bus_q == {8'h00, addr}, "R4 operand on bus", bus_q, {8'h00, addr});
        if (s == 4) chk(bus_q == mem[addr], "R5 memory word on bus", bus_q, mem[addr]);
        if (s == 5) chk(bus_q == old_g, "R6 accumulator on bus", bus_q, old_g);
        if (s == 8) chk(bus_q == new_g, "R7 result on bus", bus_q, new_g);
      end
      @(negedge clk);
    end
    model_g = new_g;
    if (add) begin
      chk(acc_q == new_g, "R7 accumulator sum", acc_q, new_g);
      chk(mem_addr == {4'h0, addr}, "R4 address register", {4'h0, mem_addr}, {8'h00, addr});
    end else begin
      chk(acc_q == old_g, "R9 accumulator held", acc_q, old_g);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++)
      mem[i] = 16'(i * 40503) ^ 16'(i << 7);
    mem[0] = 16'h0000;
    mem[1] = 16'h0001;
    mem[2] = 16'hFFFF;
    mem[3] = 16'h8000;

    repeat (3) @(negedge clk);
    chk(sc_q == 4'd0 && phase_q == 1'b0 && acc_q == 16'h0 && bus_q == 16'h0,
        "R1 reset held", acc_q, 16'h0000);
    rst_n = 1'b1;
    chk(sc_q == 4'd0 && phase_q == 1'b0 && acc_q == 16'h0 && bus_q == 16'h0,
        "R1 after release", {11'd0, phase_q, sc_q}, 16'h0000);

    // R10: FFFF then 0001 wraps to 0000; a zero word changes nothing
    run_instr(4'hA, 8'd2);
    run_instr(4'hA, 8'd1);
    chk(acc_q == 16'h0000, "R10 carry dropped", acc_q, 16'h0000);
    run_instr(4'hA, 8'd3);
    run_instr(4'hA, 8'd0);
    chk(acc_q == 16'h8000, "R10 zero operand", acc_q, 16'h8000);
    run_instr(4'hA, 8'd3);
    chk(acc_q == 16'h0000, "R10 8000+8000", acc_q, 16'h0000);

    // R9: other opcodes leave the accumulator alone
    run_instr(4'hA, 8'd77);
    for (int op = 0; op < 16; op++)
      if (op != 10) run_instr(4'(op), 8'(op * 13));

    // sweep of operand addresses, interleaved with non-add words
    for (int n = 0; n < 120; n++) begin
      if (n % 9 == 4) run_instr(4'h5, 8'(n));
      else run_instr(4'hA, 8'((n * 37 + 11) % 256));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule